// File: doc/BRIEF.md
# RTC Event Output Pin Controller

This block drives one output pad from real-time-clock events. Two single-cycle strobes arrive from the rest of the RTC: a compare-match event and a once-per-second tick. A five-bit field in a 32-bit control word enables the pad, picks which strobe drives it, sets the polarity and chooses the waveform. The block produces the pad value and an output-enable for a tri-state pad buffer.

Two waveforms are offered. In pulse mode each selected event gives one clock of active output. In level mode an event holds the pad active and raises a status flag. Software clears that flag by reading the control word, and the pad returns to inactive once the flag is cleared.

All logic runs in the RTC clock domain. Reset is asynchronous and active low. The core is a three-state machine:
- `ST_IDLE`: the output is inactive.
- `ST_PULSE`: active for this clock only.
- `ST_HOLD`: active and flagged.

Its transitions are:
- IDLE to PULSE, or PULSE to PULSE, on a selected event in pulse mode.
- IDLE to HOLD, or PULSE to HOLD, on a selected event in level mode.
- PULSE to IDLE when no event arrives.
- HOLD to IDLE on a read strobe with no coinciding event.
- Any state to IDLE while disabled, or on a write that clears the enable.

Top module: `rtc_evtpin`

## Requirements
- R1: The control word holds the pad controls, and all other bits read 0. Bit 20 is the level flag and is read-only. Bit 19 is polarity, bit 18 is waveform mode (1 = level), bit 17 is event select and bit 16 is enable. Bits 19..16 take the written value on the edge of a write strobe. All five bits are 0 after reset.
- R2: `pin_oe` equals the enable bit. When it is 0 the pad is not driven.
- R3: Event select 0 takes `cmp_evt` and ignores `sec_evt`. Event select 1 takes `sec_evt` and ignores `cmp_evt`.
- R4: The pad level reflects polarity. With polarity 0, `pin_out` is 1 when active and 0 when inactive. With polarity 1 both levels are inverted. While disabled, `pin_out` rests at the inactive level.
- R5: In pulse mode, a selected event in cycle N makes the output active in cycle N+1 only.
- R6: In level mode, a selected event in cycle N makes the output active from cycle N+1 until the flag is cleared.
- R7: The level flag becomes 1 only on a selected event in level mode. Writes to bit 20 have no effect.
- R8: A read strobe while the flag is 1, with no coinciding selected event, clears the flag and returns the pad to inactive in the next cycle. A read strobe while the flag is 0 has no effect.
- R9: Events that arrive while enable is 0 are ignored and do not set the flag.
- R10: A write that clears enable drops the flag and any pulse in the next cycle. Re-enabling then starts inactive.
- R11: A read strobe that coincides with a selected event in level mode leaves the flag at 1 and the pad active.
- R12: In pulse mode, K selected events in consecutive cycles give K consecutive active cycles with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RTC clock |
| rst_n | input | 1 | Asynchronous active-low backup-domain reset |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_re | input | 1 | Control word read strobe (clears the level flag) |
| reg_rdata | output | 32 | Control word read data |
| cmp_evt | input | 1 | Compare-match event strobe |
| sec_evt | input | 1 | One-second tick strobe |
| pin_out | output | 1 | Pad output value |
| pin_oe | output | 1 | Pad output enable |

## Verification
The bench sweeps all eight combinations of polarity, source select and waveform mode. In each combination it applies a set of event patterns:
- A single selected event separates the pulse and level waveforms and checks the polarity of each.
- An event on the unselected source shows whether the source mux is wired the right way round.
- Runs of consecutive events expose any gap or merge in pulse stretching.
- A read that coincides with an event distinguishes set-priority from clear-priority.
- Disable-while-active, events while disabled, plain reads and writes to the flag bit confirm that each of these leaves no trace on the pad or the read data.

// File: rtl/rtc_evtpin_pkg.sv
package rtc_evtpin_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned BIT_EN  = 16;
    localparam int unsigned BIT_SEL = 17;
    localparam int unsigned BIT_LVL = 18;
    localparam int unsigned BIT_POL = 19;
    localparam int unsigned BIT_FLG = 20;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_HOLD  = 2'd2
    } wave_state_t;

    typedef struct packed {
        logic pol;
        logic lvl;
        logic sel;
        logic en;
    } pin_cfg_t;
endpackage

// File: rtl/rtc_evtpin_cfg.sv
module rtc_evtpin_cfg
    import rtc_evtpin_pkg::*;
#(
    parameter int unsigned DW = WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  logic          flag,
    output pin_cfg_t      cfg,
    output logic          en_clear,
    output logic [DW-1:0] rdata
);
    pin_cfg_t cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q.en  <= wdata[BIT_EN];
            cfg_q.sel <= wdata[BIT_SEL];
            cfg_q.lvl <= wdata[BIT_LVL];
            cfg_q.pol <= wdata[BIT_POL];
        end
    end

    always_comb begin
        rdata          = '0;
        rdata[BIT_EN]  = cfg_q.en;
        rdata[BIT_SEL] = cfg_q.sel;
        rdata[BIT_LVL] = cfg_q.lvl;
        rdata[BIT_POL] = cfg_q.pol;
        rdata[BIT_FLG] = flag;
    end

    assign cfg      = cfg_q;
    assign en_clear = we & ~wdata[BIT_EN];

    assert_write_loads_R1: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (rdata[BIT_POL:BIT_EN] == $past(wdata[BIT_POL:BIT_EN])));
endmodule

// File: rtl/rtc_evtpin_evsel.sv
module rtc_evtpin_evsel (
    input  logic en,
    input  logic sel,
    input  logic cmp_evt,
    input  logic sec_evt,
    output logic evt
);
    always_comb begin
        evt = 1'b0;
        if (en) begin
            evt = sel ? sec_evt : cmp_evt;
        end
    end
endmodule

// File: rtl/rtc_evtpin_fsm.sv
module rtc_evtpin_fsm
    import rtc_evtpin_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    input  logic evt,
    input  logic lvl,
    input  logic rd,
    output logic active,
    output logic flag
);
    wave_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (!en || clr) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:  if (evt) st_d = lvl ? ST_HOLD : ST_PULSE;
                ST_PULSE: st_d = evt ? (lvl ? ST_HOLD : ST_PULSE) : ST_IDLE;
                ST_HOLD:  if (rd && !evt) st_d = ST_IDLE;
                default:  st_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (st_q)
            ST_IDLE:  begin active = 1'b0; flag = 1'b0; end
            ST_PULSE: begin active = 1'b1; flag = 1'b0; end
            ST_HOLD:  begin active = 1'b1; flag = 1'b1; end
            default:  begin active = 1'b0; flag = 1'b0; end
        endcase
    end

    assert_pulse_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !flag && !evt) |=> !active);
    assert_level_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && evt && lvl) |=> (flag && active));
    assert_flag_needs_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !(evt && lvl)) |=> !flag);
    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && rd && !evt) |=> (!flag && !active));
    assert_disabled_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !active);
    assert_clear_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!active && !flag));
    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && flag && rd && evt) |=> flag);
    assert_stretch_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && evt && !lvl && active && !flag) |=> (active && !flag));
endmodule

// File: rtl/rtc_evtpin_pad.sv
module rtc_evtpin_pad (
    input  logic en,
    input  logic pol,
    input  logic active,
    output logic pin_out,
    output logic pin_oe
);
    assign pin_oe  = en;
    assign pin_out = (en & active) ^ pol;
endmodule

// File: rtl/rtc_evtpin.sv
module rtc_evtpin
    import rtc_evtpin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic              reg_re,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              cmp_evt,
    input  logic              sec_evt,
    output logic              pin_out,
    output logic              pin_oe
);
    pin_cfg_t cfg;
    logic     en_clear;
    logic     evt;
    logic     active;
    logic     flag;

    rtc_evtpin_cfg #(.DW(WORD_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata),
        .flag(flag), .cfg(cfg), .en_clear(en_clear), .rdata(reg_rdata)
    );

    rtc_evtpin_evsel u_evsel (
        .en(cfg.en), .sel(cfg.sel), .cmp_evt(cmp_evt), .sec_evt(sec_evt), .evt(evt)
    );

    rtc_evtpin_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .en(cfg.en), .clr(en_clear), .evt(evt),
        .lvl(cfg.lvl), .rd(reg_re), .active(active), .flag(flag)
    );

    rtc_evtpin_pad u_pad (
        .en(cfg.en), .pol(cfg.pol), .active(active), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    assert_oe_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !reg_wdata[BIT_EN]) |=> !pin_oe);
    assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe |-> (pin_out == reg_rdata[BIT_POL]));
endmodule

// File: tb/rtc_evtpin_tb.sv
module rtc_evtpin_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        reg_re = 1'b0;
    logic [31:0] reg_rdata;
    logic        cmp_evt = 1'b0;
    logic        sec_evt = 1'b0;
    logic        pin_out;
    logic        pin_oe;

    int checks = 0;
    int failures = 0;

    logic m_en = 0, m_sel = 0, m_lvl = 0, m_pol = 0;
    logic m_act = 0, m_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_evtpin u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_re(reg_re), .reg_rdata(reg_rdata), .cmp_evt(cmp_evt),
        .sec_evt(sec_evt), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic logic [31:0] cw(input logic pol, input logic lvl,
                                       input logic sel, input logic en);
        return {11'd0, 1'b0, pol, lvl, sel, en, 16'd0};
    endfunction

    task automatic compare(input string tag);
        logic [31:0] exp_rd;
        logic        exp_pin;
        exp_rd  = {11'd0, m_flag, m_pol, m_lvl, m_sel, m_en, 16'd0};
        exp_pin = m_act ^ m_pol;
        checks++;
        if (pin_out !== exp_pin || pin_oe !== m_en || reg_rdata !== exp_rd) begin
            failures++;
            $display("FAIL %s: pin_out=%0b oe=%0b rdata=%h expected pin_out=%0b oe=%0b rdata=%h",
                     tag, pin_out, pin_oe, reg_rdata, exp_pin, m_en, exp_rd);
        end
    endtask

    // one clock: drive at negedge, model the edge, compare at following negedge
    task automatic step(input logic we, input logic [31:0] wd, input logic re,
                        input logic c, input logic s, input string tag);
        logic sel_e, clr;
        reg_we = we; reg_wdata = wd; reg_re = re; cmp_evt = c; sec_evt = s;
        sel_e = m_en && (m_sel ? s : c);
        clr   = we && !wd[16];
        if (!m_en || clr) begin
            m_act = 0; m_flag = 0;
        end else if (sel_e) begin
            m_act = 1; m_flag = m_flag | m_lvl;
        end else if (m_flag) begin
            if (re) begin m_act = 0; m_flag = 0; end
        end else begin
            m_act = 0;
        end
        if (we) begin
            m_en = wd[16]; m_sel = wd[17]; m_lvl = wd[18]; m_pol = wd[19];
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(input string tag);
        step(0, '0, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        compare("R1 R2 R4 reset");
        @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset release");

        for (int cfgi = 0; cfgi < 8; cfgi++) begin
            logic pol, sel, lvl, cs, ss, co, so;
            pol = cfgi[2]; lvl = cfgi[1]; sel = cfgi[0];
            cs = !sel; ss = sel; co = sel; so = !sel;

            step(1, cw(pol, lvl, sel, 1), 0, 0, 0, "R1 R2 config write");
            idle("R4 idle level");
            step(0, '0, 0, co, so, "R3 unselected source");
            idle("R3 unselected source");
            step(0, '0, 0, cs, ss, "R3 R5 R6 R7 selected event");
            idle("R5 R6 after event");
            idle("R5 R6 hold or idle");
            step(0, '0, 1, 0, 0, "R8 read strobe");
            idle("R8 after read");
            step(0, '0, 1, 0, 0, "R8 read with no flag");
            // set and read together
            step(0, '0, 0, cs, ss, "R6 arm");
            step(0, '0, 1, cs, ss, "R11 read with event");
            idle("R11 still held");
            step(0, '0, 1, 0, 0, "R8 clear");
            idle("R8 cleared");
            // back-to-back events
            for (int k = 0; k < 3; k++) step(0, '0, 0, cs, ss, "R12 consecutive events");
            idle("R12 stretch tail");
            idle("R12 end");
            step(0, '0, 1, 0, 0, "R8 final clear");
            // flag bit write ignored
            step(1, cw(pol, lvl, sel, 1) | 32'h0010_0000, 0, 0, 0, "R7 flag bit write");
            idle("R7 no flag");
            // disable while active
            step(0, '0, 0, cs, ss, "R5 R6 event before disable");
            step(1, cw(pol, lvl, sel, 0), 0, 0, 0, "R10 disable drops output");
            step(0, '0, 0, cs, ss, "R9 event while disabled");
            step(0, '0, 0, 1, 1, "R9 both events while disabled");
            step(1, cw(pol, lvl, sel, 1), 0, 0, 0, "R10 re-enable inactive");
            idle("R10 stays inactive");
            step(1, cw(pol, lvl, sel, 0), 0, 0, 0, "R2 disabled pad");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule